// File: doc/BRIEF.md
# Error-Rate Driven Supply Voltage Controller

This block closes a supply-voltage loop on timing-error feedback. A pipeline with in-situ error detection reports one error flag per clock. The controller counts the raised flags over a fixed window of samples. At the end of each window it updates an internal base voltage code, then sends a request code to an external regulator.

The update rule is proportional. A window that holds errors raises the base code by the error count shifted left by a programmable gain, so a burst of errors gives a large step up. A window with no errors lowers the base code by one LSB. Over time the supply drifts down toward the point where errors start, and it sits just above that point.

The base code is clamped between programmable lower and upper limits. An optional safety margin of about three percent (the base code shifted right by a fixed amount, then added) is applied after the limit check. The sum is clamped again, so the request never goes above the upper limit. While the enable input is low the request is frozen, and any partial window is discarded.

Top module: `errrate_vreg_ctrl`

## Requirements
- R1: After reset, `vCode` equals the parameter INIT_CODE and `codeUpdate` is 0.
- R2: While `enable` is high, a window closes on every WINDOW-th enabled clock. `codeUpdate` is a single-cycle pulse in the cycle that follows the closing edge, and it does not appear at any other time.
- R3: A window with N>0 errors (`errIn` high on N of its sampled clocks) raises the base code by N shifted left by `gainShift`.
- R4: A window with zero errors lowers the base code by exactly 1.
- R5: The base code never goes below `minCode`. A zero-error window taken at or below `minCode` leaves the base code at `minCode`.
- R6: The base code saturates at `maxCode`. `vCode` never exceeds `maxCode` at an update, even when the margin is enabled.
- R7: With `marginEn` high at the closing edge, `vCode` = min(base + (base >> MARGIN_SHIFT), `maxCode`). With `marginEn` low, `vCode` = base.
- R8: The error count restarts at zero for every window. Errors from one window never add to the next.
- R9: While `enable` is low, `vCode` holds its value and `codeUpdate` stays 0, whatever `errIn` and `marginEn` do. A window that `enable` interrupts is discarded: its errors have no effect, and counting restarts when `enable` returns.
- R10: `vCode` changes only in cycles where `codeUpdate` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the loop; low freezes the request |
| errIn | input | 1 | Timing-error flag, sampled once per clock |
| gainShift | input | GAIN_W | Left-shift amount applied to the window error count |
| minCode | input | CODE_W | Lower limit of the base code |
| maxCode | input | CODE_W | Upper limit of the base code and of the output |
| marginEn | input | 1 | Adds the safety margin to the request |
| vCode | output | CODE_W | Voltage request code to the regulator |
| codeUpdate | output | 1 | Pulses when a new request is issued |

## Verification
The bench uses WINDOW=16, CODE_W=10, GAIN_W=3, MARGIN_SHIFT=5 and INIT_CODE=512. The short window keeps runs brief. With a full window of errors at gain 7, the up-step (2048) exceeds the whole 10-bit code range, so saturation at the upper limit comes within reach. At a 10-bit base near 700, the 1/32 margin is about 21 codes. That is enough for the margin to push past a lowered upper limit and be clipped by it, and also to land below a raised one. A lowered minimum lets the bench test the floor of the zero-error walk-down.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

  // strobes issued by the window sequencer to the datapath
  typedef struct packed {
    logic sample;     // count this cycle's error flag
    logic windowEnd;  // last sample of a window: commit an update
    logic flush;      // discard the partial window
  } vreg_strobe_t;

endpackage

// File: rtl/vreg_window_ctrl.sv
module vreg_window_ctrl
  import vreg_pkg::*;
#(
  parameter int WINDOW = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  output vreg_strobe_t strb
);
  localparam int IDX_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WINDOW - 1);

  logic [IDX_W-1:0] sampleIdx;
  logic             atLast;

  assign atLast = (sampleIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampleIdx <= '0;
    end else if (!enable || atLast) begin
      sampleIdx <= '0;
    end else begin
      sampleIdx <= sampleIdx + 1'b1;
    end
  end

  always_comb begin
    strb.sample    = enable;
    strb.windowEnd = enable && atLast;
    strb.flush     = !enable;
  end

endmodule

// File: rtl/vreg_margin_shaper.sv
module vreg_margin_shaper #(
  parameter int CODE_W       = 10,
  parameter int MARGIN_SHIFT = 5
) (
  input  logic [CODE_W-1:0] baseCode,
  input  logic [CODE_W-1:0] maxCode,
  input  logic              marginEn,
  output logic [CODE_W-1:0] outCode
);
  localparam int EXT_W = CODE_W + 1;

  logic [EXT_W-1:0] withMargin;

  generate
    if (MARGIN_SHIFT > 0 && MARGIN_SHIFT < CODE_W) begin : g_margin
      assign withMargin = EXT_W'(baseCode) + EXT_W'(baseCode >> MARGIN_SHIFT);
    end else begin : g_nomargin
      assign withMargin = EXT_W'(baseCode);
    end
  endgenerate

  always_comb begin
    if (!marginEn) begin
      outCode = baseCode;
    end else if (withMargin > EXT_W'(maxCode)) begin
      outCode = maxCode;
    end else begin
      outCode = withMargin[CODE_W-1:0];
    end
  end

endmodule

// File: rtl/vreg_datapath.sv
module vreg_datapath
  import vreg_pkg::*;
#(
  parameter int CODE_W       = 10,
  parameter int GAIN_W       = 3,
  parameter int WINDOW       = 100,
  parameter int MARGIN_SHIFT = 5,
  parameter int INIT_CODE    = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vreg_strobe_t      strb,
  input  logic              errIn,
  input  logic [GAIN_W-1:0] gainShift,
  input  logic [CODE_W-1:0] minCode,
  input  logic [CODE_W-1:0] maxCode,
  input  logic              marginEn,
  output logic [CODE_W-1:0] vCode,
  output logic              codeUpdate
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam int SUM_W = CODE_W + CNT_W + (1 << GAIN_W);

  logic [CNT_W-1:0]  errCnt;
  logic [CNT_W-1:0]  windowErr;
  logic [SUM_W-1:0]  upStep;
  logic [SUM_W-1:0]  raised;
  logic [CODE_W-1:0] baseCode;
  logic [CODE_W-1:0] baseNext;
  logic [CODE_W-1:0] shapedCode;

  // error count including the flag of the current cycle
  assign windowErr = errCnt + CNT_W'(errIn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errCnt <= '0;
    end else if (strb.flush || strb.windowEnd) begin
      errCnt <= '0;
    end else if (strb.sample) begin
      errCnt <= windowErr;
    end
  end

  assign upStep = SUM_W'(windowErr) << gainShift;
  assign raised = SUM_W'(baseCode) + upStep;

  always_comb begin
    if (windowErr != '0) begin
      if (raised > SUM_W'(maxCode)) baseNext = maxCode;
      else                          baseNext = raised[CODE_W-1:0];
    end else begin
      if (baseCode > minCode) baseNext = baseCode - 1'b1;
      else                    baseNext = minCode;
    end
  end

  vreg_margin_shaper #(
    .CODE_W      (CODE_W),
    .MARGIN_SHIFT(MARGIN_SHIFT)
  ) u_shaper (
    .baseCode(baseNext),
    .maxCode (maxCode),
    .marginEn(marginEn),
    .outCode (shapedCode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseCode   <= CODE_W'(INIT_CODE);
      vCode      <= CODE_W'(INIT_CODE);
      codeUpdate <= 1'b0;
    end else begin
      codeUpdate <= strb.windowEnd;
      if (strb.windowEnd) begin
        baseCode <= baseNext;
        vCode    <= shapedCode;
      end
    end
  end

endmodule

// File: rtl/errrate_vreg_ctrl.sv
module errrate_vreg_ctrl
  import vreg_pkg::*;
#(
  parameter int CODE_W       = 10,
  parameter int GAIN_W       = 3,
  parameter int WINDOW       = 100,
  parameter int MARGIN_SHIFT = 5,
  parameter int INIT_CODE    = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              errIn,
  input  logic [GAIN_W-1:0] gainShift,
  input  logic [CODE_W-1:0] minCode,
  input  logic [CODE_W-1:0] maxCode,
  input  logic              marginEn,
  output logic [CODE_W-1:0] vCode,
  output logic              codeUpdate
);
  vreg_strobe_t strb;

  vreg_window_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(enable),
    .strb  (strb)
  );

  vreg_datapath #(
    .CODE_W      (CODE_W),
    .GAIN_W      (GAIN_W),
    .WINDOW      (WINDOW),
    .MARGIN_SHIFT(MARGIN_SHIFT),
    .INIT_CODE   (INIT_CODE)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .errIn     (errIn),
    .gainShift (gainShift),
    .minCode   (minCode),
    .maxCode   (maxCode),
    .marginEn  (marginEn),
    .vCode     (vCode),
    .codeUpdate(codeUpdate)
  );

endmodule

// File: rtl/errrate_vreg_ctrl_chk.sv
module errrate_vreg_ctrl_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [CODE_W-1:0] minCode,
  input logic [CODE_W-1:0] maxCode,
  input logic [CODE_W-1:0] vCode,
  input logic              codeUpdate
);
  // R6: a fresh request never lies above the upper limit
  p_out_le_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    codeUpdate |-> (vCode <= maxCode));

  // R5: a fresh request never lies below the lower limit (consistent limits)
  p_out_ge_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (codeUpdate && (minCode <= maxCode)) |-> (vCode >= minCode));

  // R2: the update strobe lasts one cycle
  p_update_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    codeUpdate |=> !codeUpdate);

  // R9: no update is issued while the loop is disabled
  p_frozen_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !codeUpdate);

  // R10: the request moves only together with the update strobe
  p_stable_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !codeUpdate |-> $stable(vCode));

endmodule

bind errrate_vreg_ctrl errrate_vreg_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .minCode   (minCode),
  .maxCode   (maxCode),
  .vCode     (vCode),
  .codeUpdate(codeUpdate)
);

// File: tb/tb_errrate_vreg_ctrl.sv
module tb_errrate_vreg_ctrl;
  localparam int CODE_W = 10;
  localparam int GAIN_W = 3;
  localparam int WINDOW = 16;
  localparam int MSHIFT = 5;
  localparam int INIT   = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b0;
  logic              errIn = 1'b0;
  logic [GAIN_W-1:0] gainShift = '0;
  logic [CODE_W-1:0] minCode = '0;
  logic [CODE_W-1:0] maxCode = '1;
  logic              marginEn = 1'b0;
  logic [CODE_W-1:0] vCode;
  logic              codeUpdate;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // configuration applied at the first sample of each window
  int cfgGain = 0, cfgMin = 0, cfgMax = 1023, cfgMargin = 0;
  int modelBase = INIT;

  int    expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  errrate_vreg_ctrl #(
    .CODE_W(CODE_W), .GAIN_W(GAIN_W), .WINDOW(WINDOW),
    .MARGIN_SHIFT(MSHIFT), .INIT_CODE(INIT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .errIn(errIn),
    .gainShift(gainShift), .minCode(minCode), .maxCode(maxCode),
    .marginEn(marginEn), .vCode(vCode), .codeUpdate(codeUpdate)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  function automatic int modelStep(input int nErr);
    int nb;
    if (nErr > 0) begin
      nb = modelBase + (nErr << cfgGain);
      if (nb > cfgMax) nb = cfgMax;
    end else begin
      nb = (modelBase > cfgMin) ? modelBase - 1 : cfgMin;
    end
    return nb;
  endfunction

  function automatic int shape(input int b);
    int o;
    if (cfgMargin == 0) return b;
    o = b + (b >> MSHIFT);
    return (o > cfgMax) ? cfgMax : o;
  endfunction

  // one full window with nErr error flags
  task automatic runWindow(input int nErr, input string tag);
    for (int i = 0; i < WINDOW; i++) begin
      @(negedge clk);
      if (i == 0) begin
        gainShift = GAIN_W'(cfgGain);
        minCode   = CODE_W'(cfgMin);
        maxCode   = CODE_W'(cfgMax);
        marginEn  = (cfgMargin != 0);
        modelBase = modelStep(nErr);
        expQ.push_back(shape(modelBase));
        tagQ.push_back(tag);
      end
      enable = 1'b1;
      errIn  = (i < nErr);
    end
  endtask

  // monitor: compare every issued request with the scoreboard
  always @(negedge clk) begin
    if (rst_n && codeUpdate) begin
      if (expQ.size() == 0) begin
        check("R2/R9 unexpected update", 1, 0);
      end else begin
        check(tagQ.pop_front(), int'(vCode), expQ.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check("watchdog expired", 1, 0);
      finishRun();
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    check("R1 reset vCode", int'(vCode), INIT);
    check("R1 reset codeUpdate", int'(codeUpdate), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vCode after release", int'(vCode), INIT);

    cfgMin = 400; cfgMax = 700; cfgGain = 0; cfgMargin = 0;
    runWindow(3, "R3 three errors gain 0");
    runWindow(0, "R4 quiet window down one");
    runWindow(0, "R4 quiet window down one again");
    cfgGain = 2;
    runWindow(5, "R3 five errors gain 2");
    cfgGain = 3;
    runWindow(16, "R3 full window gain 3");
    runWindow(16, "R6 saturate at max");
    cfgGain = 0; cfgMargin = 1;
    runWindow(1, "R6 margin clipped by max");
    cfgMax = 1000;
    runWindow(0, "R7 margin added");
    runWindow(0, "R7 margin added again");
    cfgMargin = 0; cfgMin = 696;
    runWindow(0, "R4 walk toward min");
    runWindow(0, "R5 reach min");
    runWindow(0, "R5 held at min");

    // R9: disabled loop ignores errors and margin changes
    @(negedge clk);
    held = int'(vCode);
    for (int i = 0; i < 30; i++) begin
      enable = 1'b0;
      errIn = i[0];
      marginEn = ~marginEn;
      @(negedge clk);
    end
    check("R9 frozen while disabled", int'(vCode), held);
    marginEn = 1'b0;

    // R9: interrupted window is discarded
    cfgMin = 600;
    minCode = CODE_W'(cfgMin);
    for (int i = 0; i < 10; i++) begin
      enable = 1'b1; errIn = 1'b1;
      @(negedge clk);
    end
    enable = 1'b0; errIn = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 no update from partial window", int'(vCode), held);
    runWindow(0, "R9 partial window errors dropped");

    // R8: count cleared between windows
    runWindow(16, "R8 burst window");
    runWindow(0, "R8 next window starts from zero");

    // R6: huge step saturates, margin stays within max
    cfgMax = 1023; cfgGain = 7; cfgMargin = 1;
    runWindow(16, "R6 gain 7 saturation with margin");
    cfgGain = 0; cfgMargin = 0;
    runWindow(0, "R4 down from top");

    @(negedge clk);
    enable = 1'b0;
    repeat (WINDOW + 4) @(negedge clk);
    check("R2 all expected updates seen", expQ.size(), 0);
    finishRun();
  end

endmodule